// File: doc/BRIEF.md
# NAND Sector ECC Generator and Checker

This block keeps a 24-bit Hamming-style parity code for every 512-byte sector of a NAND flash page. It computes the code as the page streams past one byte per valid strobe. A page is 2048 data bytes (four sectors) followed by a 64-byte spare area. The spare area is split into four 16-byte regions, and region N holds the code for sector N. A mode bit selects where the three code bytes sit inside each region. The same placement is used in both directions.

In generate mode (write toward the device), the block raises `ins_o` in the same cycle as each spare byte that should carry a code byte. It then presents that code byte on `ins_byte_o`, so the transfer path can put it in place of the byte it was about to send. In check mode (read from the device), it captures the stored code bytes from the spare stream. After the last byte of each spare region, it reports the XOR of the stored and recomputed codes as a syndrome, together with a classification. Repairing the data is left to the consumer of the syndrome.

The block acts only when the bank's ECC setting is one of the two enabling encodings and the transfer covers a full page. The accumulator always runs, but no insertion and no syndrome is produced otherwise.

Top module: `nand_sector_ecc`

## Requirements
- R1: For each sector, code bit k (k = 0..11) is the parity of all data bits whose 12-bit address {byte index within sector[8:0], bit index[2:0]} has bit k set. Code bit 12+k is the parity of the bits whose address has bit k clear.
- R2: The code restarts at every 512-byte sector boundary. A `page_start_i` pulse restarts the page byte count, so bytes streamed before it do not reach any code.
- R3: In generate mode with `place_mode_i`=0, the code of sector N is offered at spare offsets N*16+6, +7 and +8 with bits [7:0], [15:8] and [23:16] in that order. `ins_o` is high in the same cycle as that spare byte, and `spare_off_o` gives the offset.
- R4: With `place_mode_i`=1, the same three bytes go to spare offsets N*16+8, +9 and +10.
- R5: `ins_o` is low for every data byte, for every spare offset outside the code positions, and at all times in check mode.
- R6: In check mode, one cycle after the spare byte at offset N*16+15 is taken, `syn_valid_o` pulses for one cycle. At that point `syn_sector_o`=N and `syndrome_o` equals the stored code XOR the recomputed code.
- R7: A zero syndrome raises none of `err_corr_o`, `err_code_o` and `err_uncorr_o`.
- R8: A syndrome with exactly 12 bits set raises `err_corr_o` (single data-bit error).
- R9: A syndrome with exactly one bit set raises `err_code_o` (error inside the stored code).
- R10: Any other nonzero syndrome raises `err_uncorr_o`.
- R11: Unless `full_page_i` is high and `bank_ecc_i` is 2'b01 or 2'b10, `ins_o` and `syn_valid_o` stay low.
- R12: While and right after reset, `ins_o`, `syn_valid_o`, the error flags and `syndrome_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bank_ecc_i | input | 2 | Bank ECC setting; 01 and 10 enable the block |
| full_page_i | input | 1 | Transfer covers a full page |
| place_mode_i | input | 1 | Code position in spare region: 0 at +6, 1 at +8 |
| check_i | input | 1 | 1 = check (read), 0 = generate (write) |
| page_start_i | input | 1 | Restarts the page byte count |
| byte_valid_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Page byte: data first, then spare |
| ins_o | output | 1 | Current spare byte must carry a code byte |
| ins_byte_o | output | 8 | Code byte to place |
| spare_off_o | output | 6 | Spare offset of the current byte |
| syn_valid_o | output | 1 | Syndrome valid pulse |
| syn_sector_o | output | 2 | Sector of the syndrome |
| syndrome_o | output | 24 | Stored XOR recomputed code |
| err_corr_o | output | 1 | Single data-bit error |
| err_code_o | output | 1 | Single error inside the code word |
| err_uncorr_o | output | 1 | Uncorrectable error |

## Verification
The insertion outputs `ins_o`, `ins_byte_o` and `spare_off_o` are combinational on the byte being presented. The bench samples them 1 ns after it drives each byte on the falling edge, before the rising edge that takes the byte. The syndrome and its flags pass through one register, so they are due in the cycle after the rising edge that takes the byte at region offset 15. The bench checks them 1 ns after that edge, and it drives the next byte only at the falling edge that follows.

// File: rtl/nse_pkg.sv
package nse_pkg;
  typedef enum logic [1:0] {
    SYN_NONE   = 2'd0,
    SYN_CORR   = 2'd1,
    SYN_CODE   = 2'd2,
    SYN_UNCORR = 2'd3
  } syn_class_e;

  // bits of a byte whose bit index has address bit k set
  function automatic logic [7:0] col_mask(input int k);
    logic [7:0] m;
    for (int b = 0; b < 8; b++) begin
      logic [2:0] bi;
      bi = 3'(b);
      m[b] = bi[k];
    end
    return m;
  endfunction
endpackage

// File: rtl/nse_parity_acc.sv
module nse_parity_acc #(
  parameter int unsigned SECTOR_BYTES = 512,
  localparam int unsigned POS_W  = $clog2(SECTOR_BYTES),
  localparam int unsigned ADDR_W = POS_W + 3,
  localparam int unsigned CODE_W = 2 * ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              first_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [7:0]        data_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] acc_q;
  logic [CODE_W-1:0] contrib;
  logic              byte_par;

  assign byte_par = ^data_i;

  for (genvar k = 0; k < 3; k++) begin : g_col
    assign contrib[k]          = ^(data_i & nse_pkg::col_mask(k));
    assign contrib[ADDR_W + k] = ^(data_i & ~nse_pkg::col_mask(k));
  end

  for (genvar j = 0; j < POS_W; j++) begin : g_row
    assign contrib[3 + j]          = pos_i[j] & byte_par;
    assign contrib[ADDR_W + 3 + j] = ~pos_i[j] & byte_par;
  end

  // running code including the current byte
  assign code_o = (first_i ? '0 : acc_q) ^ contrib;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (take_i) acc_q <= code_o;
  end
endmodule

// File: rtl/nse_spare_map.sv
module nse_spare_map #(
  parameter int unsigned REGION_BYTES = 16,
  parameter int unsigned REGIONS      = 4,
  parameter int unsigned CODE_BYTES   = 3,
  parameter int unsigned BASE0        = 6,
  parameter int unsigned BASE1        = 8,
  localparam int unsigned REL_W  = $clog2(REGION_BYTES),
  localparam int unsigned REG_W  = $clog2(REGIONS),
  localparam int unsigned OFF_W  = REL_W + REG_W,
  localparam int unsigned LANE_W = $clog2(CODE_BYTES)
) (
  input  logic [OFF_W-1:0]  off_i,
  input  logic              mode_i,
  output logic              hit_o,
  output logic [REG_W-1:0]  region_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              last_o
);
  logic [REL_W-1:0] rel;
  logic [REL_W-1:0] base;
  logic [REL_W:0]   diff;

  assign rel      = off_i[REL_W-1:0];
  assign region_o = off_i[OFF_W-1:REL_W];
  assign base     = mode_i ? REL_W'(BASE1) : REL_W'(BASE0);
  assign diff     = {1'b0, rel} - {1'b0, base};
  assign hit_o    = !diff[REL_W] && (diff < (REL_W + 1)'(CODE_BYTES));
  assign lane_o   = diff[LANE_W-1:0];
  assign last_o   = &rel;
endmodule

// File: rtl/nse_syn_class.sv
module nse_syn_class #(
  parameter int unsigned CODE_W = 24
) (
  input  logic [CODE_W-1:0]  syn_i,
  output nse_pkg::syn_class_e class_o
);
  int unsigned ones;

  always_comb begin
    ones = $countones(syn_i);
    if (ones == 0)               class_o = nse_pkg::SYN_NONE;
    else if (ones == CODE_W / 2) class_o = nse_pkg::SYN_CORR;
    else if (ones == 1)          class_o = nse_pkg::SYN_CODE;
    else                         class_o = nse_pkg::SYN_UNCORR;
  end
endmodule

// File: rtl/nand_sector_ecc.sv
module nand_sector_ecc #(
  parameter int unsigned SECTOR_BYTES = 512,
  parameter int unsigned SECTORS      = 4,
  parameter int unsigned REGION_BYTES = 16,
  parameter int unsigned CODE_BASE0   = 6,
  parameter int unsigned CODE_BASE1   = 8,
  localparam int unsigned POS_W       = $clog2(SECTOR_BYTES),
  localparam int unsigned SEC_W       = $clog2(SECTORS),
  localparam int unsigned CODE_W      = 2 * (POS_W + 3),
  localparam int unsigned CODE_BYTES  = CODE_W / 8,
  localparam int unsigned LANE_W      = $clog2(CODE_BYTES),
  localparam int unsigned PAGE_DATA   = SECTOR_BYTES * SECTORS,
  localparam int unsigned SPARE_BYTES = REGION_BYTES * SECTORS,
  localparam int unsigned PAGE_BYTES  = PAGE_DATA + SPARE_BYTES,
  localparam int unsigned CNT_W       = $clog2(PAGE_BYTES + 1),
  localparam int unsigned OFF_W       = $clog2(SPARE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        bank_ecc_i,
  input  logic              full_page_i,
  input  logic              place_mode_i,
  input  logic              check_i,
  input  logic              page_start_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  output logic              ins_o,
  output logic [7:0]        ins_byte_o,
  output logic [OFF_W-1:0]  spare_off_o,
  output logic              syn_valid_o,
  output logic [SEC_W-1:0]  syn_sector_o,
  output logic [CODE_W-1:0] syndrome_o,
  output logic              err_corr_o,
  output logic              err_code_o,
  output logic              err_uncorr_o
);
  logic [CNT_W-1:0]  cnt_q, idx;
  logic              take, data_ph, en;
  logic [POS_W-1:0]  pos;
  logic [SEC_W-1:0]  sec;
  logic [OFF_W-1:0]  off;
  logic [CODE_W-1:0] acc_code;
  logic              hit, last;
  logic [SEC_W-1:0]  region;
  logic [LANE_W-1:0] lane;
  logic [CODE_W-1:0] codes_q  [SECTORS];
  logic [CODE_W-1:0] stored_q [SECTORS];
  logic [CODE_W-1:0] syn_q;
  logic [SEC_W-1:0]  syn_sec_q;
  logic              syn_v_q;
  nse_pkg::syn_class_e cls;

  assign en      = full_page_i && (bank_ecc_i == 2'b01 || bank_ecc_i == 2'b10);
  assign idx     = page_start_i ? '0 : cnt_q;
  assign take    = byte_valid_i && (idx < CNT_W'(PAGE_BYTES));
  assign data_ph = idx < CNT_W'(PAGE_DATA);
  assign pos     = idx[POS_W-1:0];
  assign sec     = idx[POS_W +: SEC_W];
  assign off     = idx[OFF_W-1:0]; // data area is a multiple of the spare size

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (take)         cnt_q <= idx + 1'b1;
    else if (page_start_i) cnt_q <= '0;
  end

  nse_parity_acc #(.SECTOR_BYTES(SECTOR_BYTES)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (take && data_ph),
    .first_i (pos == '0),
    .pos_i   (pos),
    .data_i  (byte_i),
    .code_o  (acc_code)
  );

  nse_spare_map #(
    .REGION_BYTES (REGION_BYTES),
    .REGIONS      (SECTORS),
    .CODE_BYTES   (CODE_BYTES),
    .BASE0        (CODE_BASE0),
    .BASE1        (CODE_BASE1)
  ) u_map (
    .off_i    (off),
    .mode_i   (place_mode_i),
    .hit_o    (hit),
    .region_o (region),
    .lane_o   (lane),
    .last_o   (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SECTORS; s++) begin
        codes_q[s]  <= '0;
        stored_q[s] <= '0;
      end
    end else begin
      if (take && data_ph && (&pos)) codes_q[sec] <= acc_code;
      if (take && !data_ph && check_i && hit)
        stored_q[region][{lane, 3'b000} +: 8] <= byte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      syn_q     <= '0;
      syn_sec_q <= '0;
      syn_v_q   <= 1'b0;
    end else begin
      syn_v_q <= 1'b0;
      if (take && !data_ph && check_i && en && last) begin
        syn_q     <= stored_q[region] ^ codes_q[region];
        syn_sec_q <= region;
        syn_v_q   <= 1'b1;
      end
    end
  end

  nse_syn_class #(.CODE_W(CODE_W)) u_cls (
    .syn_i   (syn_q),
    .class_o (cls)
  );

  assign ins_o        = en && !check_i && take && !data_ph && hit;
  assign ins_byte_o   = codes_q[region][{lane, 3'b000} +: 8];
  assign spare_off_o  = data_ph ? '0 : off;
  assign syn_valid_o  = syn_v_q;
  assign syn_sector_o = syn_sec_q;
  assign syndrome_o   = syn_q;
  assign err_corr_o   = syn_v_q && (cls == nse_pkg::SYN_CORR);
  assign err_code_o   = syn_v_q && (cls == nse_pkg::SYN_CODE);
  assign err_uncorr_o = syn_v_q && (cls == nse_pkg::SYN_UNCORR);

  // R5
  ins_gen_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_o |-> (byte_valid_i && !check_i));

  // R6
  syn_after_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    syn_valid_o |-> $past(byte_valid_i && check_i));

  // R6
  syn_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    syn_valid_o |=> !syn_valid_o);

  // R11
  syn_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    syn_valid_o |-> $past(en));

  // R8
  corr_weight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_corr_o |-> ($countones(syndrome_o) == CODE_W / 2));

  // R10
  flags_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({err_corr_o, err_code_o, err_uncorr_o}));
endmodule

// File: tb/nand_sector_ecc_test.sv
module nand_sector_ecc_test;
  localparam int DATA_B  = 2048;
  localparam int SPARE_B = 64;
  localparam int NVEC    = 7;
  // {check, mode, pattern[1:0], flip kind[1:0], flip sector[1:0], 2'b0, class[1:0]}
  localparam logic [11:0] VECS [NVEC] = '{
    12'h000, 12'h500, 12'h900, 12'hF61, 12'h892, 12'hEF3, 12'hC41
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bank_ecc = 2'b01;
  logic full_page = 1'b1, place_mode = 1'b0, check = 1'b0;
  logic page_start = 1'b0, byte_valid = 1'b0;
  logic [7:0] byte_d = 8'h00;
  logic ins, syn_valid, err_corr, err_code, err_uncorr;
  logic [7:0] ins_byte;
  logic [5:0] spare_off;
  logic [1:0] syn_sector;
  logic [23:0] syndrome;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string note = "";

  logic [7:0]  pg [DATA_B];
  logic [7:0]  sp [SPARE_B];
  logic [23:0] rc [4];
  logic [23:0] sc [4];

  always #5 clk = ~clk;

  nand_sector_ecc uut (
    .clk_i(clk), .rst_ni(rst_n), .bank_ecc_i(bank_ecc), .full_page_i(full_page),
    .place_mode_i(place_mode), .check_i(check), .page_start_i(page_start),
    .byte_valid_i(byte_valid), .byte_i(byte_d), .ins_o(ins), .ins_byte_o(ins_byte),
    .spare_off_o(spare_off), .syn_valid_o(syn_valid), .syn_sector_o(syn_sector),
    .syndrome_o(syndrome), .err_corr_o(err_corr), .err_code_o(err_code),
    .err_uncorr_o(err_uncorr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, note, act, exp);
    end
  endtask

  function automatic logic [7:0] pat_byte(input int p, input int i);
    case (p)
      0:       return 8'(i);
      1:       return 8'(i * 37 + 5);
      2:       return 8'hFF;
      default: return 8'(i >> 3) ^ 8'h5A;
    endcase
  endfunction

  // independent bit-level code: bit k = address bit k set, bit 12+k = clear (R1)
  task automatic calc_rc();
    for (int s = 0; s < 4; s++) begin
      logic [23:0] c;
      c = '0;
      for (int j = 0; j < 512; j++) begin
        for (int b = 0; b < 8; b++) begin
          if (pg[s*512 + j][b]) begin
            logic [11:0] a;
            a = {9'(j), 3'(b)};
            for (int k = 0; k < 12; k++)
              if (a[k]) c[k] = ~c[k]; else c[12+k] = ~c[12+k];
          end
        end
      end
      rc[s] = c;
    end
  endtask

  task automatic fill(input int p);
    for (int i = 0; i < DATA_B; i++) pg[i] = pat_byte(p, i);
    for (int i = 0; i < SPARE_B; i++) sp[i] = 8'hFF;
  endtask

  task automatic place_codes(input logic mode);
    for (int n = 0; n < 4; n++)
      for (int l = 0; l < 3; l++)
        sp[n*16 + (mode ? 8 : 6) + l] = sc[n][l*8 +: 8];
  endtask

  task automatic run_page(input logic chk_m, input logic mode, input logic [1:0] bank,
                          input logic full, input int cls_sec, input int cls_exp);
    bit en_exp;
    en_exp = full && (bank == 2'b01 || bank == 2'b10);
    @(negedge clk);
    bank_ecc = bank; full_page = full; place_mode = mode; check = chk_m;
    page_start = 1'b1; byte_valid = 1'b0;
    @(posedge clk);
    for (int i = 0; i < DATA_B + SPARE_B; i++) begin
      int o, rel, rg, base;
      bit hit_e;
      o = i - DATA_B; rel = o % 16; rg = o / 16; base = mode ? 8 : 6;
      @(negedge clk);
      page_start = 1'b0; byte_valid = 1'b1;
      byte_d = (i < DATA_B) ? pg[i] : sp[o];
      #1;
      if (i < DATA_B) begin
        chk(ins == 1'b0, "R5", 32'(ins), 0);
      end else begin
        hit_e = en_exp && !chk_m && rel >= base && rel < base + 3;
        chk(ins == hit_e, !en_exp ? "R11" : (hit_e ? (mode ? "R4" : "R3") : "R5"),
            32'(ins), 32'(hit_e));
        if (hit_e) begin
          chk(ins_byte == rc[rg][(rel-base)*8 +: 8], "R1", 32'(ins_byte),
              32'(rc[rg][(rel-base)*8 +: 8]));
          chk(spare_off == 6'(o), mode ? "R4" : "R3", 32'(spare_off), 32'(o));
        end
      end
      @(posedge clk);
      #1;
      if (i >= DATA_B && rel == 15 && chk_m) begin
        if (!en_exp) begin
          chk(syn_valid == 1'b0, "R11", 32'(syn_valid), 0);
        end else begin
          int ce;
          logic [2:0] fe;
          ce = (rg == cls_sec) ? cls_exp : 0;
          fe = (ce == 1) ? 3'b001 : (ce == 2) ? 3'b010 : (ce == 3) ? 3'b100 : 3'b000;
          chk(syn_valid == 1'b1, "R6", 32'(syn_valid), 1);
          chk(syn_sector == 2'(rg), "R6", 32'(syn_sector), 32'(rg));
          chk(syndrome == (sc[rg] ^ rc[rg]), "R6", 32'(syndrome), 32'(sc[rg] ^ rc[rg]));
          chk({err_uncorr, err_code, err_corr} == fe,
              ce == 0 ? "R7" : ce == 1 ? "R8" : ce == 2 ? "R9" : "R10",
              32'({err_uncorr, err_code, err_corr}), 32'(fe));
        end
      end
    end
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  // builds clean codes into sc, applies the flip, recomputes rc from the data sent
  task automatic prep(input logic [11:0] v);
    int fb;
    fill(int'(v[9:8]));
    calc_rc();
    for (int s = 0; s < 4; s++) sc[s] = rc[s];
    fb = int'(v[5:4]) * 512 + 77;
    case (v[7:6])
      2'd1: pg[fb] = pg[fb] ^ 8'h08;
      2'd2: sc[v[5:4]] = sc[v[5:4]] ^ 24'h000020;
      2'd3: pg[fb] = pg[fb] ^ 8'h18;
      default: ;
    endcase
    calc_rc();
    place_codes(v[10]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R12
    chk(ins == 1'b0 && syn_valid == 1'b0, "R12", {30'b0, ins, syn_valid}, 0);
    chk({err_corr, err_code, err_uncorr} == 3'b000 && syndrome == '0, "R12",
        32'(syndrome), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(ins == 1'b0 && syn_valid == 1'b0, "R12", {30'b0, ins, syn_valid}, 0);

    for (int e = 0; e < NVEC; e++) begin
      logic [11:0] v;
      v = VECS[e];
      $sformat(note, "vec%0d", e);
      prep(v);
      run_page(v[11], v[10], (e % 2 == 1) ? 2'b10 : 2'b01, 1'b1,
               int'(v[5:4]), int'(v[1:0]));
    end

    // R2: partial page abandoned mid-sector, then restart
    note = "R2 restart";
    @(negedge clk);
    page_start = 1'b1; byte_valid = 1'b0; check = 1'b0;
    @(posedge clk);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      page_start = 1'b0; byte_valid = 1'b1; byte_d = 8'h3C;
      @(posedge clk);
    end
    prep(12'h300);
    run_page(1'b0, 1'b0, 2'b01, 1'b1, 0, 0);

    // R11: disabled encodings and partial transfers
    note = "R11 bank00";
    prep(12'hF61);
    run_page(1'b1, 1'b1, 2'b00, 1'b1, 2, 1);
    note = "R11 bank11";
    prep(12'h100);
    run_page(1'b0, 1'b0, 2'b11, 1'b1, 0, 0);
    note = "R11 partial";
    prep(12'h900);
    run_page(1'b0, 1'b1, 2'b10, 1'b0, 0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule